// File: doc/BRIEF.md
# Round-Robin Hardware Thread Scheduler

This block decides, on every clock, which of a core's hardware thread slots issues its next vector instruction. Each slot is empty, runnable, waiting or finished. One runnable slot is granted per cycle, and the grant rotates: the search starts at the slot after the one that issued last. A running slot that reports a stall is parked on the wait list and is not considered again until a wake event for that slot arrives.

When a slot's thread signals that it is done, the slot moves to a finished state. The block then reports it upstream with a completion message that carries the slot index and the thread descriptor. Once reported, the slot is empty. An empty slot pops the entry at the head of an external dispatch FIFO. That entry holds a descriptor and a kind bit, which marks either a fresh stateless thread or a blocked stateful thread being resumed. The loaded slot becomes runnable.

Top module: `rr_thread_sched`

## Requirements
- R1: While reset is asserted, and after its release with nothing dispatched, `issue_oh`, `cmpl_valid` and `disp_pop` are 0.
- R2: `issue_oh` has at most one bit set in any cycle, and only a runnable slot is granted.
- R3: The granted slot is the first runnable slot at or after the slot following the previously granted slot, searching upward with wrap-around. The search position does not move in cycles with no grant. After reset it starts at slot 0.
- R4: A runnable slot that has `slot_stall` high in a cycle, without `slot_done`, is waiting from the next cycle. A waiting slot is never granted.
- R5: A waiting slot that has `slot_wake` high becomes runnable from the next cycle. `slot_wake` on a slot that is not waiting has no effect.
- R6: A runnable or waiting slot that has `slot_done` high is finished from the next cycle. Each cycle in which any slot is finished, the lowest finished slot is reported: `cmpl_valid`=1, with `cmpl_slot` and `cmpl_desc` set to that slot's index and descriptor. The reported slot is empty from the next cycle.
- R7: When `disp_valid` is high and some slot is empty, `disp_pop` is high in that cycle. The lowest empty slot takes `disp_desc`/`disp_kind` and is runnable from the next cycle. At most one slot is loaded per cycle.
- R8: When `disp_valid` is low, `disp_pop` stays low and empty slots stay empty.
- R9: While a slot is granted, `issue_desc` and `issue_kind` show the descriptor and kind bit (1 = resume, 0 = new) that the slot was loaded with.
- R10: `slot_done` takes priority over `slot_stall` and `slot_wake` in the same cycle. Inputs for empty or finished slots are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch FIFO holds an entry at its head |
| disp_desc | input | DESC_W | Descriptor at the dispatch FIFO head |
| disp_kind | input | 1 | 1 = resume a stateful thread, 0 = start a new thread |
| disp_pop | output | 1 | Head entry is consumed at this clock edge |
| slot_stall | input | NSLOTS | Per-slot stall report |
| slot_wake | input | NSLOTS | Per-slot wake event |
| slot_done | input | NSLOTS | Per-slot thread completion |
| issue_oh | output | NSLOTS | One-hot issue grant, 0 when idle |
| issue_desc | output | DESC_W | Descriptor of the granted slot |
| issue_kind | output | 1 | Kind bit of the granted slot |
| cmpl_valid | output | 1 | Completion message valid |
| cmpl_slot | output | IW | Slot index of the completed thread |
| cmpl_desc | output | DESC_W | Descriptor of the completed thread |

## Verification
A corrupted slot state appears at the ports within one cycle. A slot stuck as runnable still gets grants after a stall or done. A slot stuck as waiting loses its turn after a wake. A finished slot that is never cleared repeats its completion message and never pops the FIFO. A wrong rotation pointer moves the grant to an out-of-turn slot on the very next cycle with two or more runnable slots. A behavioural model therefore compares every output on every cycle, under long random stall, wake, done and dispatch traffic and under bursts in which all slots complete together.

// File: rtl/rr_sched_pkg.sv
package rr_sched_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_RUN   = 2'd1,
    SLOT_WAIT  = 2'd2,
    SLOT_FIN   = 2'd3
  } slot_st_e;
endpackage

// File: rtl/rr_pick.sv
// Rotating first-one finder: grants the first set request at or after start.
module rr_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    int p;
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      p = (int'(start) + k) % N;
      if (!any && req[p]) begin
        any    = 1'b1;
        gnt[p] = 1'b1;
        idx    = IW'(p);
      end
    end
  end
endmodule

// File: rtl/rr_slot.sv
// State and payload of one hardware thread slot.
module rr_slot
  import rr_sched_pkg::*;
#(
  parameter int DESC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DESC_W-1:0] load_desc,
  input  logic              load_kind,
  input  logic              stall,
  input  logic              wake,
  input  logic              done,
  input  logic              reported,
  output slot_st_e          st,
  output logic [DESC_W-1:0] desc,
  output logic              kind
);
  slot_st_e st_d;
  logic     pay_en;

  always_comb begin
    st_d   = st;
    pay_en = 1'b0;
    case (st)
      SLOT_EMPTY: if (load) begin
        st_d   = SLOT_RUN;
        pay_en = 1'b1;
      end
      SLOT_RUN: begin
        if (done)       st_d = SLOT_FIN;
        else if (stall) st_d = SLOT_WAIT;
      end
      SLOT_WAIT: begin
        if (done)      st_d = SLOT_FIN;
        else if (wake) st_d = SLOT_RUN;
      end
      SLOT_FIN: if (reported) st_d = SLOT_EMPTY;
      default: st_d = SLOT_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SLOT_EMPTY;
    else        st <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc <= '0;
      kind <= 1'b0;
    end else if (pay_en) begin
      desc <= load_desc;
      kind <= load_kind;
    end
  end
endmodule

// File: rtl/rr_thread_sched.sv
module rr_thread_sched
  import rr_sched_pkg::*;
#(
  parameter int NSLOTS = 4,
  parameter int DESC_W = 8,
  localparam int IW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [DESC_W-1:0] disp_desc,
  input  logic              disp_kind,
  output logic              disp_pop,
  input  logic [NSLOTS-1:0] slot_stall,
  input  logic [NSLOTS-1:0] slot_wake,
  input  logic [NSLOTS-1:0] slot_done,
  output logic [NSLOTS-1:0] issue_oh,
  output logic [DESC_W-1:0] issue_desc,
  output logic              issue_kind,
  output logic              cmpl_valid,
  output logic [IW-1:0]     cmpl_slot,
  output logic [DESC_W-1:0] cmpl_desc
);
  slot_st_e          st    [NSLOTS];
  logic [DESC_W-1:0] sdesc [NSLOTS];
  logic [NSLOTS-1:0] skind;
  logic [NSLOTS-1:0] run_mask, empty_mask, fin_mask;
  logic [NSLOTS-1:0] fill_oh, rep_oh;
  logic [IW-1:0]     iss_idx, fill_idx, rep_idx;
  logic              iss_any, fill_any, rep_any;
  logic [IW-1:0]     rr_ptr, rr_ptr_d;
  logic              rr_ptr_en;

  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
    assign run_mask[i]   = (st[i] == SLOT_RUN);
    assign empty_mask[i] = (st[i] == SLOT_EMPTY);
    assign fin_mask[i]   = (st[i] == SLOT_FIN);

    rr_slot #(.DESC_W(DESC_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (disp_pop & fill_oh[i]),
      .load_desc (disp_desc),
      .load_kind (disp_kind),
      .stall     (slot_stall[i]),
      .wake      (slot_wake[i]),
      .done      (slot_done[i]),
      .reported  (rep_oh[i]),
      .st        (st[i]),
      .desc      (sdesc[i]),
      .kind      (skind[i])
    );
  end

  rr_pick #(.N(NSLOTS), .IW(IW)) u_issue_pick (
    .req(run_mask), .start(rr_ptr), .gnt(issue_oh), .idx(iss_idx), .any(iss_any)
  );

  rr_pick #(.N(NSLOTS), .IW(IW)) u_fill_pick (
    .req(empty_mask), .start('0), .gnt(fill_oh), .idx(fill_idx), .any(fill_any)
  );

  rr_pick #(.N(NSLOTS), .IW(IW)) u_report_pick (
    .req(fin_mask), .start('0), .gnt(rep_oh), .idx(rep_idx), .any(rep_any)
  );

  assign disp_pop   = disp_valid & fill_any;
  assign issue_desc = iss_any ? sdesc[iss_idx] : '0;
  assign issue_kind = iss_any & skind[iss_idx];
  assign cmpl_valid = rep_any;
  assign cmpl_slot  = rep_idx;
  assign cmpl_desc  = rep_any ? sdesc[rep_idx] : '0;

  always_comb begin
    rr_ptr_en = iss_any;
    if (int'(iss_idx) == NSLOTS - 1) rr_ptr_d = '0;
    else                             rr_ptr_d = iss_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rr_ptr <= '0;
    else if (rr_ptr_en) rr_ptr <= rr_ptr_d;
  end
endmodule

// File: rtl/rr_thread_sched_chk.sv
module rr_thread_sched_chk #(
  parameter int NSLOTS = 4,
  parameter int IW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_valid,
  input logic              disp_pop,
  input logic [NSLOTS-1:0] slot_stall,
  input logic [NSLOTS-1:0] slot_done,
  input logic [NSLOTS-1:0] issue_oh,
  input logic              cmpl_valid,
  input logic [IW-1:0]     cmpl_slot
);
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_oh));

  p_pop_needs_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_pop |-> disp_valid);

  p_report_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |=> !(cmpl_valid && cmpl_slot == $past(cmpl_slot)));

  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot_chk
    p_stalled_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_oh[i] && slot_stall[i] && !slot_done[i]) |=> !issue_oh[i]);

    p_done_stops_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_oh[i] && slot_done[i]) |=> !issue_oh[i]);
  end
endmodule

bind rr_thread_sched rr_thread_sched_chk #(.NSLOTS(NSLOTS), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_valid (disp_valid),
  .disp_pop   (disp_pop),
  .slot_stall (slot_stall),
  .slot_done  (slot_done),
  .issue_oh   (issue_oh),
  .cmpl_valid (cmpl_valid),
  .cmpl_slot  (cmpl_slot)
);

// File: tb/test_rr_thread_sched.sv
`timescale 1ns/1ps
module test_rr_thread_sched;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          disp_valid, disp_kind, disp_pop;
  logic [DW-1:0] disp_desc;
  logic [N-1:0]  slot_stall, slot_wake, slot_done, issue_oh;
  logic [DW-1:0] issue_desc, cmpl_desc;
  logic          issue_kind, cmpl_valid;
  logic [IW-1:0] cmpl_slot;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  rr_thread_sched #(.NSLOTS(N), .DESC_W(DW)) i_rr_thread_sched (
    .clk, .rst_n, .disp_valid, .disp_desc, .disp_kind, .disp_pop,
    .slot_stall, .slot_wake, .slot_done, .issue_oh, .issue_desc,
    .issue_kind, .cmpl_valid, .cmpl_slot, .cmpl_desc
  );

  // Reference model: 0 empty, 1 runnable, 2 waiting, 3 finished
  int       mst [N];
  int       mdesc [N];
  int       mkind [N];
  int       mptr;
  bit [8:0] fq [$];
  bit       woke_prev, prio_prev;
  int       exp_iss, exp_rep, exp_fill;
  bit       exp_pop;

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_outputs();
    exp_iss = -1; exp_rep = -1; exp_fill = -1;
    for (int k = 0; k < N; k++) begin
      int p;
      p = (mptr + k) % N;
      if (exp_iss < 0 && mst[p] == 1) exp_iss = p;
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (mst[i] == 3) exp_rep = i;
      if (mst[i] == 0) exp_fill = i;
    end
    exp_pop = (fq.size() > 0) && (exp_fill >= 0);
  endtask

  task automatic compare();
    logic [N-1:0] waitm;
    waitm = '0;
    for (int i = 0; i < N; i++) if (mst[i] == 2) waitm[i] = 1'b1;
    check(woke_prev ? "R5" : "R3", issue_oh, (exp_iss >= 0) ? (1 << exp_iss) : 0);
    check("R2", $countones(issue_oh) <= 1, 1);
    if (waitm != 0) check("R4", issue_oh & waitm, 0);
    if (exp_iss >= 0) begin
      check("R9", issue_desc, mdesc[exp_iss]);
      check("R9", issue_kind, mkind[exp_iss]);
    end
    check(prio_prev ? "R10" : "R6", cmpl_valid, exp_rep >= 0);
    if (exp_rep >= 0) begin
      check("R6", cmpl_slot, exp_rep);
      check("R6", cmpl_desc, mdesc[exp_rep]);
    end
    check((fq.size() == 0) ? "R8" : "R7", disp_pop, exp_pop);
  endtask

  task automatic model_update();
    woke_prev = 0; prio_prev = 0;
    for (int i = 0; i < N; i++) begin
      case (mst[i])
        1: begin
          if (slot_done[i]) begin mst[i] = 3; prio_prev |= slot_stall[i]; end
          else if (slot_stall[i]) mst[i] = 2;
        end
        2: begin
          if (slot_done[i]) begin mst[i] = 3; prio_prev |= slot_wake[i]; end
          else if (slot_wake[i]) begin mst[i] = 1; woke_prev = 1; end
        end
        3: if (i == exp_rep) mst[i] = 0;
        default: if (exp_pop && i == exp_fill) begin
          mst[i] = 1; mdesc[i] = fq[0][7:0]; mkind[i] = fq[0][8];
        end
      endcase
    end
    if (exp_pop) void'(fq.pop_front());
    if (exp_iss >= 0) mptr = (exp_iss + 1) % N;
  endtask

  task automatic step(int push_pct, logic [N-1:0] force_done);
    @(negedge clk);
    if (($urandom % 100) < push_pct) fq.push_back(9'($urandom));
    disp_valid = fq.size() > 0;
    disp_desc  = (fq.size() > 0) ? fq[0][7:0] : '0;
    disp_kind  = (fq.size() > 0) ? fq[0][8] : 1'b0;
    for (int i = 0; i < N; i++) begin
      slot_stall[i] = ($urandom % 8) == 0;
      slot_wake[i]  = ($urandom % 3) == 0;
      slot_done[i]  = (($urandom % 10) == 0) | force_done[i];
    end
    #1;
    model_outputs();
    compare();
    @(posedge clk);
    model_update();
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    disp_valid = 1'b0; disp_desc = '0; disp_kind = 1'b0;
    slot_stall = '0; slot_wake = '0; slot_done = '0;
    for (int i = 0; i < N; i++) begin mst[i] = 0; mdesc[i] = 0; mkind[i] = 0; end
    mptr = 0; woke_prev = 0; prio_prev = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", issue_oh, 0);
    check("R1", cmpl_valid, 0);
    check("R1", disp_pop, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: no dispatch entries, slots stay empty
    for (int c = 0; c < 30; c++) step(0, '0);
    // Fill all slots and run mixed traffic
    for (int c = 0; c < 3000; c++) step(35, '0);
    // Bursts with every slot completing together
    for (int c = 0; c < 400; c++) step(60, (c % 25 == 0) ? '1 : '0);
    // Starve the FIFO so slots drain and wait empty, then refill
    for (int c = 0; c < 200; c++) step(0, '0);
    for (int c = 0; c < 400; c++) step(20, '0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule